// File: doc/BRIEF.md
# Paged Byte-Wide Nonvolatile Memory Model

This block is a synthesizable stand-in for a byte-wide, electrically rewritable nonvolatile memory that sits on a parallel bus with three active-low strobes (chip select, output enable and write strobe). The block decodes each bus state. It drives read data only during a proper read cycle. A write is not placed in the array at once. It is first collected in a 64-byte page latch, and the latch is committed to the array when the bus has been quiet for a page window. A commit starts an internal programming interval. During that interval the block reports busy, returns 0xFF to readers and refuses further writes.

The array depth is the parameter `ADDR_W`: 15 gives the full 32K x 8 device, and the default of 11 keeps the elaborated array small. The array is set to the erased value 0xFF at power-up, and reset leaves it untouched. `PAGE_TMO` sets the page window in clock cycles and `PROG_CYC` sets the programming interval. A page window of zero writes each byte through at once, and a programming interval of zero removes the busy state. A write-protect input can be changed at any time and blocks all writes while it is high.

Top module: `nvm_page_emu`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0 and `we_n`=1, and no programming in progress, `dq_oe` is 1 and `dq_out` carries the byte stored at `addr`. Never-written locations read 0xFF.
- R2: `dq_oe` is 0 whenever `ce_n` is 1 or `oe_n` is 1.
- R3: When `ce_n`, `oe_n` and `we_n` are all 0, `clash` is 1 and `dq_oe` is 0, and the cycle is taken as a write.
- R4: A write is captured once, on the first rising clock edge at which `ce_n` and `we_n` are both seen low. Keeping the strobe low longer, even with changing data, writes nothing more.
- R5: Bytes written to the same page (equal `addr[ADDR_W-1:6]`) are held in the page latch and committed together once `PAGE_TMO` cycles pass with no new write to that page. Each in-page write restarts the window. Before the commit, reads return the old array contents.
- R6: The byte position in a page is `addr[5:0]`, so a stream that steps from offset 63 to offset 0 stays in the same page, and both bytes commit together.
- R7: `busy` rises in the cycle after a commit and stays high for exactly `PROG_CYC` cycles. While `busy` is 1, a read still drives the bus but returns 0xFF.
- R8: A write attempted while `busy` is 1 is dropped and changes no location.
- R9: A write to a different page while a page is pending commits the pending page at once, which raises `busy` in the next cycle. The new write itself is dropped.
- R10: While `wp` is 1, write cycles are ignored and the array keeps its contents. Clearing `wp` lets writes through again.
- R11: A synchronous active-low reset clears the page latch and both timers (`busy`=0) and keeps all array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of latch and timers |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| wp | input | 1 | Write protect, 1 blocks all writes |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data toward the bus |
| dq_oe | output | 1 | 1 when the bus is driven; 0 means high impedance |
| busy | output | 1 | Programming interval in progress |
| clash | output | 1 | Output enable and write strobe both active while selected |

## Verification
The write path is tried with several patterns. A pair of writes at offsets 63 and 0 of one page separates commit-together from per-byte commits. Two in-page writes spaced wider than the window, though each closer than it, show whether the timer restarts. A held-low strobe with data that changes underneath it exposes repeated capture, and a write to a second page while one is pending separates early closure from timeout closure. Reads are placed before a commit, during programming and after it, so that stale data, the 0xFF mask and the committed byte can each be told apart. Protected writes, a clash cycle and a reset with a page still pending show which paths leave the array untouched.

// File: rtl/nvm_emu_pkg.sv
// Package: shared bus-state type for the paged nonvolatile memory model.
// Assumes: nothing beyond IEEE 1800-2017.
package nvm_emu_pkg;

    // Decoded state of the three active-low strobes.
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2,
        BUS_CLASH = 2'd3
    } bus_kind_t;

endpackage

// File: rtl/nvm_bus_decode.sv
// Module: nvm_bus_decode
// Classifies the strobe state each cycle and produces a single-cycle write
// start pulse on the first clock edge that sees select and write low.
// Assumes: strobes are already synchronous to clk (or slow enough to sample).
module nvm_bus_decode
    import nvm_emu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    output bus_kind_t kind,
    output logic      wr_start
);

    logic wr_level;
    logic wr_level_q;

    // Classify strobes; the write strobe wins over output enable.
    always_comb begin
        if (!ce_n && !we_n)
            kind = oe_n ? BUS_WRITE : BUS_CLASH;
        else if (!ce_n && !oe_n)
            kind = BUS_READ;
        else
            kind = BUS_IDLE;
    end

    assign wr_level = (kind == BUS_WRITE) || (kind == BUS_CLASH);

    // Remember the previous write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_level_q <= 1'b0;
        else
            wr_level_q <= wr_level;
    end

    assign wr_start = wr_level && !wr_level_q;

endmodule

// File: rtl/nvm_page_buf.sv
// Module: nvm_page_buf
// Collects accepted writes for one page and issues a commit bundle when the
// page window expires or a write for another page arrives. With TMO == 0
// every accepted write is passed straight through as a one-byte commit.
// Assumes: wr_req is already gated by write protect and busy.
module nvm_page_buf #(
    parameter int unsigned AW  = 11,
    parameter int unsigned PW  = 6,
    parameter int unsigned DW  = 8,
    parameter int unsigned TMO = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic                   cm_valid,
    output logic [AW-PW-1:0]       cm_base,
    output logic [(1<<PW)-1:0]     cm_mask,
    output logic [(1<<PW)-1:0][DW-1:0] cm_data
);

    localparam int unsigned PSZ = 1 << PW;
    localparam int unsigned BW  = AW - PW;
    localparam int unsigned TCW = (TMO < 2) ? 1 : $clog2(TMO + 1);

    logic [BW-1:0] in_base;
    logic [PW-1:0] in_off;

    assign in_base = wr_addr[AW-1:PW];
    assign in_off  = wr_addr[PW-1:0];

    generate
        if (TMO == 0) begin : g_direct
            // Write-through: one byte per commit, no pending state.
            always_comb begin
                cm_valid = wr_req;
                cm_base  = in_base;
                cm_mask  = '0;
                cm_mask[in_off] = 1'b1;
                for (int i = 0; i < PSZ; i++)
                    cm_data[i] = wr_data;
            end
        end else begin : g_paged
            logic                   pend_q;
            logic [BW-1:0]          base_q;
            logic [PSZ-1:0]         mask_q;
            logic [PSZ-1:0][DW-1:0] data_q;
            logic [TCW-1:0]         cnt_q;
            logic                   same_pg;
            logic                   foreign;
            logic                   expire;

            // Decide whether this cycle closes the pending page.
            always_comb begin
                same_pg = pend_q && (base_q == in_base);
                foreign = wr_req && pend_q && !same_pg;
                expire  = pend_q && (cnt_q == TCW'(1)) && !(wr_req && same_pg);
            end

            assign cm_valid = foreign || expire;
            assign cm_base  = base_q;
            assign cm_mask  = mask_q;
            assign cm_data  = data_q;

            // Page latch state, byte lanes and window timer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                    mask_q <= '0;
                    cnt_q  <= '0;
                    base_q <= '0;
                end else if (cm_valid) begin
                    pend_q <= 1'b0;
                    mask_q <= '0;
                    cnt_q  <= '0;
                end else if (wr_req) begin
                    pend_q         <= 1'b1;
                    base_q         <= in_base;
                    mask_q[in_off] <= 1'b1;
                    cnt_q          <= TCW'(TMO);
                end else if (pend_q) begin
                    cnt_q <= cnt_q - TCW'(1);
                end
            end

            // Byte lanes carry no reset; the mask qualifies them.
            always_ff @(posedge clk) begin
                if (wr_req && !cm_valid)
                    data_q[in_off] <= wr_data;
            end
        end
    endgenerate

endmodule

// File: rtl/nvm_prog_timer.sv
// Module: nvm_prog_timer
// Models the internal programming interval: busy for PROG cycles after each
// start pulse. PROG == 0 removes the busy state entirely.
// Assumes: start does not arrive while busy (callers gate writes on busy).
module nvm_prog_timer #(
    parameter int unsigned PROG = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    generate
        if (PROG == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_count
            localparam int unsigned CW = $clog2(PROG + 1);
            logic [CW-1:0] cnt_q;

            // Load on start, count down to zero otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (start)
                    cnt_q <= CW'(PROG);
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - CW'(1);
            end

            assign busy = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/nvm_page_emu.sv
// Module: nvm_page_emu (top)
// Byte-wide paged nonvolatile memory model: strobe decode, page latch,
// programming timer and the storage array. Array contents start erased
// (0xFF) and survive reset. A page commit writes all marked lanes in one
// clock.
// Assumes: strobes sampled on clk; ADDR_W > PAGE_W.
module nvm_page_emu
    import nvm_emu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned PAGE_W   = 6,
    parameter int unsigned PAGE_TMO = 32,
    parameter int unsigned PROG_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy,
    output logic              clash
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PSZ   = 1 << PAGE_W;
    localparam int unsigned BW    = ADDR_W - PAGE_W;

    bus_kind_t                  kind;
    logic                       wr_start;
    logic                       wr_go;
    logic                       cm_valid;
    logic [BW-1:0]              cm_base;
    logic [PSZ-1:0]             cm_mask;
    logic [PSZ-1:0][DATA_W-1:0] cm_data;
    logic [DATA_W-1:0]          mem [DEPTH];

    nvm_bus_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .kind     (kind),
        .wr_start (wr_start)
    );

    // Writes proceed only when unprotected and not programming.
    assign wr_go = wr_start && !wp && !busy;

    nvm_page_buf #(
        .AW  (ADDR_W),
        .PW  (PAGE_W),
        .DW  (DATA_W),
        .TMO (PAGE_TMO)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_go),
        .wr_addr  (addr),
        .wr_data  (dq_in),
        .cm_valid (cm_valid),
        .cm_base  (cm_base),
        .cm_mask  (cm_mask),
        .cm_data  (cm_data)
    );

    nvm_prog_timer #(
        .PROG (PROG_CYC)
    ) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cm_valid),
        .busy  (busy)
    );

    // Power-up image: erased array.
    initial begin
        for (int k = 0; k < DEPTH; k++)
            mem[k] = '1;
    end

    // Commit all marked page lanes into the array in one cycle.
    always_ff @(posedge clk) begin
        if (cm_valid) begin
            for (int i = 0; i < PSZ; i++) begin
                if (cm_mask[i])
                    mem[{cm_base, PAGE_W'(i)}] <= cm_data[i];
            end
        end
    end

    // Read path: array byte, masked to all ones while programming.
    assign dq_out = busy ? '1 : mem[addr];
    assign dq_oe  = (kind == BUS_READ);
    assign clash  = (kind == BUS_CLASH);

endmodule

// File: rtl/nvm_page_emu_chk.sv
// Module: nvm_page_emu_chk
// Property checker for nvm_page_emu, attached by the bind below.
// Assumes: the top's default-style port names.
module nvm_page_emu_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned PROG_CYC = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              busy,
    input logic              clash
);

    logic [31:0] busy_run;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 32'd1;
        else
            busy_run <= '0;
    end

    // R2
    hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dq_oe);

    // R3
    clash_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> !dq_oe);

    // R7
    busy_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out == '1));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= PROG_CYC);

endmodule

bind nvm_page_emu nvm_page_emu_chk #(
    .DATA_W   (DATA_W),
    .PROG_CYC (PROG_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .dq_oe  (dq_oe),
    .dq_out (dq_out),
    .busy   (busy),
    .clash  (clash)
);

// File: tb/tb_nvm_page_emu.sv
// Scoreboard bench for nvm_page_emu with default parameters.
module tb_nvm_page_emu;

    localparam int AW  = 11;
    localparam int TMO = 32;
    localparam int PRG = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          wp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;
    logic          busy;
    logic          clash;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit         oe;
        logic [7:0] d;
        string      tag;
    } exp_t;

    exp_t q[$];
    event smp;

    always #10 clk = ~clk;

    nvm_page_emu dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .wp     (wp),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe),
        .busy   (busy),
        .clash  (clash)
    );

    // Monitor: pop the expected item and compare with the bus.
    initial begin
        forever begin
            @(smp);
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
                    n_bad++;
                    $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                             e.tag, dq_oe, dq_out, e.oe, e.d);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        q.push_back('{1'b1, e, tag});
        #2 -> smp;
        #2;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic hz(input logic c, input logic o, input string tag);
        @(negedge clk);
        we_n = 1'b1; ce_n = c; oe_n = o;
        q.push_back('{1'b0, 8'h00, tag});
        #2 -> smp;
        #2;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic settle();
        repeat (TMO + 4) @(negedge clk);
        wait_idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    // Driver: stimulus and expectations.
    initial begin
        int n;
        int len;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy, 1'b0, "R11 busy after reset");
        chk(dq_oe, 1'b0, "R11 bus released in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased location
        rd(11'h010, 8'hFF, "R1 erased read");
        // R2: deselected or output disabled
        hz(1'b0, 1'b1, "R2 oe_n high");
        hz(1'b1, 1'b0, "R2 ce_n high");

        // R6 / R5: offsets 63 and 0 of page 1
        wr(11'h07F, 8'hA5);
        wr(11'h040, 8'h5A);
        rd(11'h07F, 8'hFF, "R5 old data before commit");
        chk(busy, 1'b0, "R5 no busy while collecting");
        n = 0;
        while (!busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
        chk_int(len, PRG, "R7 busy length");
        rd(11'h07F, 8'hA5, "R6 offset 63 committed");
        rd(11'h040, 8'h5A, "R6 offset 0 same page");

        // R5: window restart, then R7 read mask and R8 busy lockout
        wr(11'h100, 8'h11);
        repeat (20) @(negedge clk);
        wr(11'h101, 8'h22);
        repeat (20) @(negedge clk);
        chk(busy, 1'b0, "R5 window restarted by in-page write");
        n = 0;
        while (!busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        rd(11'h100, 8'hFF, "R7 read masked while busy");
        wr(11'h105, 8'h77);
        wait_idle();
        settle();
        rd(11'h100, 8'h11, "R5 first byte");
        rd(11'h101, 8'h22, "R5 second byte");
        rd(11'h105, 8'hFF, "R8 write during busy dropped");

        // R4: held strobe with changing data
        @(negedge clk);
        addr = 11'h200; dq_in = 8'h33; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        dq_in = 8'h44;
        repeat (8) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        settle();
        rd(11'h200, 8'h33, "R4 single capture");

        // R9: foreign page closes pending page
        wr(11'h300, 8'h66);
        wr(11'h340, 8'h77);
        chk(busy, 1'b1, "R9 busy right after foreign write");
        wait_idle();
        settle();
        rd(11'h300, 8'h66, "R9 pending page committed");
        rd(11'h340, 8'hFF, "R9 foreign write dropped");

        // R10: write protect
        wp = 1'b1;
        wr(11'h400, 8'h12);
        repeat (TMO + 8) @(negedge clk);
        chk(busy, 1'b0, "R10 no programming under protect");
        rd(11'h400, 8'hFF, "R10 protected write ignored");
        wp = 1'b0;
        wr(11'h400, 8'h34);
        settle();
        rd(11'h400, 8'h34, "R10 write after unprotect");

        // R3: clash cycle treated as write
        @(negedge clk);
        addr = 11'h500; dq_in = 8'h9C; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        q.push_back('{1'b0, 8'h00, "R3 no drive on clash"});
        #2 -> smp;
        chk(clash, 1'b1, "R3 clash flag");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk(clash, 1'b0, "R3 clash cleared");
        settle();
        rd(11'h500, 8'h9C, "R3 clash wrote data");

        // R11: reset with a page pending
        wr(11'h600, 8'hAB);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (TMO + 8) @(negedge clk);
        chk(busy, 1'b0, "R11 no commit after reset");
        rd(11'h600, 8'hFF, "R11 pending page discarded");
        rd(11'h07F, 8'hA5, "R11 array kept across reset");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule